// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block turns single write requests from an internal bus into asynchronous write cycles on an external static memory or NOR-style device. After it accepts a request, it drives the address, an active-low chip enable, an active-low address-valid strobe, an active-low output enable and an active-low write enable. It also drives the write data with an output-enable flag for the data pads. Each cycle has three parts: an address setup phase of programmable length, a data setup phase of programmable length in which the write strobe is low, and one closing clock in which the write strobe is high again while the chip is still selected.

A small configuration register sets the cycle. One bit allows writes at all. One bit chooses between the common timing register and a separate write-timing register. Two bits set how the external wait input is handled: one makes the sequencer honour it, the other gives the level that means "wait". Every access is a single transfer. There is no read path, burst, wrapping or synchronous write.

Top module: `ext_mem_write_seq`

## Requirements
- R1: After a request is accepted, the address phase starts on the next clock and lasts (address-setup + 1) clocks. In this phase chip enable and address-valid are low and write enable is high.
- R2: The data phase follows the address phase directly and lasts max(data-setup, 1) clocks, plus any stall cycles. In this phase write enable is low and address-valid is high.
- R3: After the data phase comes exactly one clock with chip enable low and write enable high. Chip enable then goes high and the cycle ends.
- R4: When the extended-timing bit is 0, both setup values come from the common timing register (select 1). When it is 1, they come from the write timing register (select 2). The choice is made at the moment the request is accepted.
- R5: Output enable stays high at all times.
- R6: When the write-allow bit is 0, a request is accepted but produces no memory activity. Chip enable, address-valid and write enable stay high, and ready stays high.
- R7: When wait-honour is 1, each clock edge in the data phase at which the wait input equals the wait-level bit holds the data phase for one more clock. When wait-honour is 0, the wait input has no effect.
- R8: Address and write data are captured at acceptance and held stable for the whole cycle. The data-drive flag is high exactly while chip enable is low.
- R9: After reset, all strobes are high, the data-drive flag is low and req_ready is high. req_ready is low from the clock after acceptance until the cycle ends.
- R10: Configuration layout. Select 0 is the control register: bit 0 write-allow, bit 1 extended timing, bit 2 wait-honour, bit 3 wait-level (1 means high = wait). For selects 1 and 2, the low ASET_W bits hold address-setup and the next DSET_W bits hold data-setup. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | ASET_W+DSET_W | Configuration write data |
| req_valid | input | 1 | Write request |
| req_ready | output | 1 | Sequencer idle, request accepted when both high |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request write data |
| mem_wait | input | 1 | External wait input |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | DW | Write data |
| mem_dout_en | output | 1 | Data pad drive enable |

## Verification
The bench places the request on a falling edge, and the request is accepted at the next rising edge. The first address-phase cycle is then visible at the falling edge after that. From there the bench samples every falling edge until chip enable rises, and counts how many samples show address-valid, write enable and chip enable low. It also records the index of the first write-enable sample. The expected values follow from the requirements: A+1 samples for the address phase, max(D,1) plus stalls for write enable, and that total plus one for the whole cycle. The bench drives wait levels at falling edges only, so each active level covers exactly one stalled rising edge.

// File: rtl/ext_mem_write_pkg.sv
package ext_mem_write_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_COMMON = 2'd1;
  localparam logic [1:0] SEL_WRITE = 2'd2;

  localparam int CTL_ALLOW = 0;
  localparam int CTL_EXT = 1;
  localparam int CTL_WAIT_EN = 2;
  localparam int CTL_WAIT_LVL = 3;
  localparam int CTL_W = 4;

endpackage

// File: rtl/ext_mem_cfg_regs.sv
module ext_mem_cfg_regs
  import ext_mem_write_pkg::*;
#(
  parameter int ASET_W = 4,
  parameter int DSET_W = 8,
  localparam int CFG_W = ASET_W + DSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              wr_allow,
  output logic              ext_mode,
  output logic              wait_en,
  output logic              wait_lvl,
  output logic [ASET_W-1:0] aset_common,
  output logic [DSET_W-1:0] dset_common,
  output logic [ASET_W-1:0] aset_write,
  output logic [DSET_W-1:0] dset_write
);

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [CFG_W-1:0] tcom_q, tcom_d;
  logic [CFG_W-1:0] twr_q, twr_d;
  logic ctl_en, tcom_en, twr_en;

  always_comb begin
    ctl_en  = cfg_we && (cfg_sel == SEL_CTRL);
    tcom_en = cfg_we && (cfg_sel == SEL_COMMON);
    twr_en  = cfg_we && (cfg_sel == SEL_WRITE);
    ctl_d   = cfg_wdata[CTL_W-1:0];
    tcom_d  = cfg_wdata;
    twr_d   = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      tcom_q <= '0;
      twr_q  <= '0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (tcom_en) tcom_q <= tcom_d;
      if (twr_en)  twr_q  <= twr_d;
    end
  end

  assign wr_allow    = ctl_q[CTL_ALLOW];
  assign ext_mode    = ctl_q[CTL_EXT];
  assign wait_en     = ctl_q[CTL_WAIT_EN];
  assign wait_lvl    = ctl_q[CTL_WAIT_LVL];
  assign aset_common = tcom_q[ASET_W-1:0];
  assign dset_common = tcom_q[CFG_W-1:ASET_W];
  assign aset_write  = twr_q[ASET_W-1:0];
  assign dset_write  = twr_q[CFG_W-1:ASET_W];

endmodule

// File: rtl/ext_mem_timing_sel.sv
module ext_mem_timing_sel #(
  parameter int ASET_W = 4,
  parameter int DSET_W = 8
) (
  input  logic              ext_mode,
  input  logic [ASET_W-1:0] aset_common,
  input  logic [DSET_W-1:0] dset_common,
  input  logic [ASET_W-1:0] aset_write,
  input  logic [DSET_W-1:0] dset_write,
  output logic [ASET_W-1:0] aset_sel,
  output logic [DSET_W-1:0] dlen_m1
);

  logic [DSET_W-1:0] dset_raw;

  always_comb begin
    if (ext_mode) begin
      aset_sel = aset_write;
      dset_raw = dset_write;
    end else begin
      aset_sel = aset_common;
      dset_raw = dset_common;
    end
    // a zero data setup is stretched to one clock; store length minus one
    if (dset_raw == '0) dlen_m1 = '0;
    else                dlen_m1 = dset_raw - 1'b1;
  end

endmodule

// File: rtl/ext_mem_phase_cnt.sv
module ext_mem_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || dec;
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);

endmodule

// File: rtl/ext_mem_write_seq.sv
module ext_mem_write_seq
  import ext_mem_write_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 16,
  parameter int ASET_W = 4,
  parameter int DSET_W = 8,
  localparam int CFG_W = ASET_W + DSET_W,
  localparam int CW = (ASET_W > DSET_W) ? ASET_W : DSET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic             mem_wait,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en
);

  logic              wr_allow, ext_mode, wait_en, wait_lvl;
  logic [ASET_W-1:0] aset_common, aset_write, aset_sel;
  logic [DSET_W-1:0] dset_common, dset_write, dlen_m1;

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic [DSET_W-1:0] dlen_q;
  logic              accept, cap_en, stall;
  logic              cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0]     cnt_load_val;

  ext_mem_cfg_regs #(.ASET_W(ASET_W), .DSET_W(DSET_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_allow(wr_allow), .ext_mode(ext_mode),
    .wait_en(wait_en), .wait_lvl(wait_lvl),
    .aset_common(aset_common), .dset_common(dset_common),
    .aset_write(aset_write), .dset_write(dset_write)
  );

  ext_mem_timing_sel #(.ASET_W(ASET_W), .DSET_W(DSET_W)) u_tsel (
    .ext_mode(ext_mode), .aset_common(aset_common), .dset_common(dset_common),
    .aset_write(aset_write), .dset_write(dset_write),
    .aset_sel(aset_sel), .dlen_m1(dlen_m1)
  );

  ext_mem_phase_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  always_comb begin
    accept       = req_valid && (state_q == ST_IDLE);
    cap_en       = accept && wr_allow;
    stall        = wait_en && (mem_wait == wait_lvl);
    state_d      = state_q;
    cnt_load     = 1'b0;
    cnt_dec      = 1'b0;
    cnt_load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cap_en) begin
          state_d      = ST_ADDR;
          cnt_load     = 1'b1;
          cnt_load_val = CW'(aset_sel);
        end
      end
      ST_ADDR: begin
        if (cnt_zero) begin
          state_d      = ST_DATA;
          cnt_load     = 1'b1;
          cnt_load_val = CW'(dlen_q);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_DATA: begin
        if (!stall) begin
          if (cnt_zero) state_d = ST_HOLD;
          else          cnt_dec = 1'b1;
        end
      end
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      dlen_q <= '0;
    end else if (cap_en) begin
      addr_q <= req_addr;
      data_q <= req_data;
      dlen_q <= dlen_m1;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_addr    = addr_q;
  assign mem_dout    = data_q;
  assign mem_ce_n    = (state_q == ST_IDLE);
  assign mem_adv_n   = (state_q != ST_ADDR);
  assign mem_we_n    = (state_q != ST_DATA);
  assign mem_oe_n    = 1'b1;
  assign mem_dout_en = (state_q != ST_IDLE);

  p_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n) mem_oe_n);
  p_adv_excl_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_we_n && !mem_ce_n));
  p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_we_before_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mem_we_n) && mem_we_n) |-> !mem_ce_n);
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mem_ce_n) && !mem_ce_n) |-> ($stable(mem_addr) && $stable(mem_dout)));
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);
  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !wr_allow) |=> mem_ce_n);

endmodule

// File: tb/ext_mem_write_seq_bench.sv
module ext_mem_write_seq_bench;

  localparam int AW = 26;
  localparam int DW = 16;
  localparam int ASET_W = 4;
  localparam int DSET_W = 8;
  localparam int CFG_W = ASET_W + DSET_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic mem_wait = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [DW-1:0] mem_dout;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_mem_write_seq #(.AW(AW), .DW(DW), .ASET_W(ASET_W), .DSET_W(DSET_W)) u_ext_mem_write_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .mem_wait(mem_wait),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = CFG_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int timing(input int a, input int d);
    return a + (d << ASET_W);
  endfunction

  // one write; expA/expD are the effective setup values, act_lvl the waiting level
  task automatic do_write(input int a_addr, input int a_data, input int expA,
                          input int expD, input int drv_stalls, input int exp_stalls,
                          input bit act_lvl, input bit exp_active);
    int adv_cnt = 0, we_cnt = 0, ce_cnt = 0, first_we = -1, wcnt = 0;
    int stab_bad = 0, oe_bad = 0, rdy_bad = 0, en_bad = 0;
    bit seen = 0, fin = 0;
    int dlen = (expD == 0) ? 1 : expD;
    mem_wait = ~act_lvl;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a_addr); req_data = DW'(a_data);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 80 && !fin; i++) begin
      if (!mem_oe_n) oe_bad++;
      if (mem_dout_en != !mem_ce_n) en_bad++;
      if (!mem_ce_n) begin
        seen = 1;
        ce_cnt++;
        if (!mem_adv_n) adv_cnt++;
        if (!mem_we_n) begin
          we_cnt++;
          if (first_we < 0) first_we = i;
          if (wcnt < drv_stalls) begin mem_wait = act_lvl; wcnt++; end
          else mem_wait = ~act_lvl;
        end
        if (mem_addr != AW'(a_addr) || mem_dout != DW'(a_data)) stab_bad++;
        if (req_ready) rdy_bad++;
      end else if (seen || (!exp_active && i >= 12)) begin
        fin = 1;
      end
      if (!fin) @(negedge clk);
    end
    mem_wait = ~act_lvl;
    check(oe_bad == 0, "R5 oe_n high", oe_bad, 0);
    check(en_bad == 0, "R8 drive flag", en_bad, 0);
    if (exp_active) begin
      check(adv_cnt == expA + 1, "R1 address phase length", adv_cnt, expA + 1);
      check(first_we == expA + 1, "R1 write strobe start", first_we, expA + 1);
      check(we_cnt == dlen + exp_stalls, "R2/R7 data phase length", we_cnt, dlen + exp_stalls);
      check(ce_cnt == expA + dlen + exp_stalls + 2, "R3 chip enable length", ce_cnt,
            expA + dlen + exp_stalls + 2);
      check(stab_bad == 0, "R8 address/data stable", stab_bad, 0);
      check(rdy_bad == 0, "R9 ready low while busy", rdy_bad, 0);
      check(req_ready == 1'b1, "R9 ready after cycle", req_ready, 1);
    end else begin
      check(ce_cnt == 0, "R6 no chip enable", ce_cnt, 0);
      check(we_cnt == 0, "R6 no write strobe", we_cnt, 0);
      check(req_ready == 1'b1, "R6 ready stays high", req_ready, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_adv_n && mem_we_n && mem_oe_n, "R9 reset strobes",
          {mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n}, 15);
    check(req_ready && !mem_dout_en, "R9 reset ready", {req_ready, mem_dout_en}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: write-allow clear (reset value) blocks activity
    cfg_write(2'd1, timing(2, 3));
    do_write(32'h123, 16'hbeef, 2, 3, 0, 0, 1'b1, 1'b0);
    // R4 + R1..R3 sweep over timing source and small setup values (R10 layout)
    for (int e = 0; e < 2; e++) begin
      cfg_write(2'd0, 1 + (e << 1));
      for (int a = 0; a < 4; a++) begin
        for (int d = 0; d < 4; d++) begin
          if (e == 0) begin
            cfg_write(2'd1, timing(a, d));
            cfg_write(2'd2, timing(9, 7));
          end else begin
            cfg_write(2'd2, timing(a, d));
            cfg_write(2'd1, timing(11, 6));
          end
          do_write((e << 20) + (a << 8) + d, (a * 37 + d * 5 + e) & 16'hffff,
                   a, d, 0, 0, 1'b1, 1'b1);
        end
      end
    end
    // R7: wait honoured, high level means wait
    cfg_write(2'd0, 1 + 4 + 8);
    cfg_write(2'd1, timing(1, 2));
    do_write(32'h55, 16'h1234, 1, 2, 3, 3, 1'b1, 1'b1);
    // R7: low level means wait
    cfg_write(2'd0, 1 + 4);
    do_write(32'h56, 16'h4321, 1, 2, 2, 2, 1'b0, 1'b1);
    // R7: zero data setup with stalls
    cfg_write(2'd1, timing(0, 0));
    do_write(32'h57, 16'h0f0f, 0, 0, 4, 4, 1'b0, 1'b1);
    // R7: wait disabled, input ignored
    cfg_write(2'd0, 1 + 8);
    cfg_write(2'd1, timing(2, 2));
    do_write(32'h58, 16'haaaa, 2, 2, 3, 0, 1'b1, 1'b1);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule